// File: doc/BRIEF.md
# First-Error Address Violation Capture

This block watches the command stream of one memory transaction port and tests each command's address against the size of the memory region the controller can reach. An address at or above the region size is a violation. The first violation after reset, or after software re-arms the block, latches the command's address, its direction and its source port number into capture registers. It also sets a valid flag. The valid flag drives an interrupt line to the host processor.

Capture is sticky. While the valid flag is set, further violations are dropped and the captured contents stay as they are. Software reads the fields and then writes a zero into bit 0 of the status register, which re-arms capture. Writing a one to that bit does nothing. Commands inside the region never affect the block.

Top module: `addr_err_capture`

## Requirements
- R1: After reset, `err_valid_o`, `irq_o`, `err_addr_o`, `err_write_o` and `err_port_o` are all zero.
- R2: A command with `cmd_valid_i`=1 and `cmd_addr_i` >= `region_size_i`, arriving while capture is armed, sets `err_valid_o` on the next clock edge. On the same edge, `err_addr_o`, `err_write_o` and `err_port_o` load that command's address, its `cmd_write_i` value (1 = write, 0 = read) and its `cmd_port_i` value.
- R3: A command with `cmd_addr_i` < `region_size_i` is not a violation and leaves every output unchanged. An address of `region_size_i`-1 is in range, and an address equal to `region_size_i` is a violation.
- R4: While `cmd_valid_i`=0, the address inputs have no effect, even when the address is out of range.
- R5: While `err_valid_o`=1 and no clear is written, later violations leave all captured fields and the valid flag unchanged.
- R6: A register write (`reg_wr_i`=1) with `reg_wdata_i[0]`=0 clears `err_valid_o` on the next edge. A write with `reg_wdata_i[0]`=1 has no effect.
- R7: `status_o[0]` equals `err_valid_o`, and `status_o[31:1]` reads as zero.
- R8: `irq_o` is a level that equals `err_valid_o` in every cycle.
- R9: If a violation and a clearing write occur in the same cycle, the new violation is captured: the valid flag stays 1 and the fields take the new command's values.
- R10: Clearing the valid flag keeps the captured fields. They change only at the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_addr_i | input | AW | Command address |
| cmd_write_i | input | 1 | Command direction, 1 = write |
| cmd_port_i | input | PW | Originating port number |
| region_size_i | input | AW | Size of the addressable region |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 32 | Status register write data |
| err_valid_o | output | 1 | Capture valid flag |
| err_addr_o | output | AW | Captured address |
| err_write_o | output | 1 | Captured direction |
| err_port_o | output | PW | Captured port number |
| status_o | output | 32 | Status register read value |
| irq_o | output | 1 | Interrupt level |

## Verification
A bounds compare that is off by one shows at the ports one cycle after a command at address `region_size_i` or `region_size_i`-1: the valid flag comes up when it should not, or stays low when it should come up. The bench sweeps every size and address pair of a 4-bit configuration, so a wrong compare shows up within a single command. A bad arming term shows in one of two ways. Either the fields move on the second violation, or the valid flag drops on a cycle where a violation and a clear coincide. Both show one cycle after the event. Lost field retention shows on the first cycle after a clear.

// File: rtl/addr_err_pkg.sv
package addr_err_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned VALID_BIT = 0;
endpackage

// File: rtl/aec_bound_chk.sv
module aec_bound_chk #(
  parameter int unsigned AW = 32
) (
  input  logic          cmd_valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] size_i,
  output logic          hit_o
);
  // region spans [0, size); size itself is outside
  assign hit_o = cmd_valid_i && (addr_i >= size_i);
endmodule

// File: rtl/aec_clr_decode.sv
module aec_clr_decode
  import addr_err_pkg::*;
(
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             clr_o
);
  logic [REG_W-1:0] unused_wdata;
  assign unused_wdata = reg_wdata_i;
  // only a zero written to the valid bit re-arms
  assign clr_o = reg_wr_i && !reg_wdata_i[VALID_BIT];
endmodule

// File: rtl/aec_capture.sv
module aec_capture #(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          clr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  input  logic [PW-1:0] port_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          write_o,
  output logic [PW-1:0] port_o
);
  logic valid_q;
  logic take;

  // armed when empty, or when software clears in this very cycle
  assign take = hit_i && (!valid_q || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_o  <= '0;
      write_o <= 1'b0;
      port_o  <= '0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        addr_o  <= addr_i;
        write_o <= write_i;
        port_o  <= port_i;
      end else if (clr_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;

  // R2
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && !valid_o |=> valid_o && addr_o == $past(addr_i) && port_o == $past(port_i));
  // R5
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !clr_i |=> valid_o && $stable(addr_o) && $stable(write_o) && $stable(port_o));
  // R6
  clear_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit_i |=> !valid_o);
  // R9
  clear_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && hit_i |=> valid_o && addr_o == $past(addr_i));
  // R10
  field_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(addr_o) && $stable(port_o));
endmodule

// File: rtl/addr_err_capture.sv
module addr_err_capture
  import addr_err_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic             cmd_write_i,
  input  logic [PW-1:0]    cmd_port_i,
  input  logic [AW-1:0]    region_size_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             err_valid_o,
  output logic [AW-1:0]    err_addr_o,
  output logic             err_write_o,
  output logic [PW-1:0]    err_port_o,
  output logic [REG_W-1:0] status_o,
  output logic             irq_o
);
  logic hit, clr;

  aec_bound_chk #(.AW(AW)) u_bound (
    .cmd_valid_i(cmd_valid_i),
    .addr_i     (cmd_addr_i),
    .size_i     (region_size_i),
    .hit_o      (hit)
  );

  aec_clr_decode u_clr (
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .clr_o      (clr)
  );

  aec_capture #(.AW(AW), .PW(PW)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (clr),
    .addr_i (cmd_addr_i),
    .write_i(cmd_write_i),
    .port_i (cmd_port_i),
    .valid_o(err_valid_o),
    .addr_o (err_addr_o),
    .write_o(err_write_o),
    .port_o (err_port_o)
  );

  always_comb begin
    status_o            = '0;
    status_o[VALID_BIT] = err_valid_o;
  end

  assign irq_o = err_valid_o;

  // R3
  in_range_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_valid_o && !(cmd_valid_i && cmd_addr_i >= region_size_i) |=> !err_valid_o);
  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i && !err_valid_o |=> !err_valid_o);
  // R6
  set_one_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o && reg_wr_i && reg_wdata_i[VALID_BIT] |=> err_valid_o);
endmodule

// File: tb/tb_addr_err_capture.sv
module tb_addr_err_capture;
  localparam int AW = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [PW-1:0] cmd_port = '0;
  logic [AW-1:0] region_size = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic          err_valid, err_write, irq;
  logic [AW-1:0] err_addr;
  logic [PW-1:0] err_port;
  logic [31:0]   status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_err_capture #(.AW(AW), .PW(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr),
    .cmd_write_i(cmd_write), .cmd_port_i(cmd_port), .region_size_i(region_size),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .err_valid_o(err_valid),
    .err_addr_o(err_addr), .err_write_o(err_write), .err_port_o(err_port),
    .status_o(status), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_fields(input string req, input int a, input int w, input int p);
    chk(err_addr == a[AW-1:0], req, int'(err_addr), a);
    chk(err_write == w[0], req, int'(err_write), w);
    chk(err_port == p[PW-1:0], req, int'(err_port), p);
  endtask

  // drive for one edge, then sample at the following negedge
  task automatic step(input bit v, input int a, input bit w, input int p,
                      input bit wr, input bit wbit);
    cmd_valid = v; cmd_addr = a[AW-1:0]; cmd_write = w; cmd_port = p[PW-1:0];
    reg_wr = wr; reg_wdata = {31'h7fff_ffff & {31{wr}}, wbit};
    @(negedge clk);
    cmd_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic chk_flag(input string req, input bit exp);
    chk(err_valid == exp, req, int'(err_valid), int'(exp));
    chk(irq == exp, {req, "/R8"}, int'(irq), int'(exp));
    chk(status == {31'd0, exp}, {req, "/R7"}, int'(status), int'(exp));
  endtask

  initial begin
    #1;
    // R1: reset state
    chk_flag("R1", 1'b0);
    chk_fields("R1", 0, 0, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2 R3 sweep of every size/address pair, plus R5 stickiness
    for (int s = 0; s < 16; s++) begin
      for (int a = 0; a < 16; a++) begin
        bit exp_hit;
        int p;
        region_size = s[AW-1:0];
        step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
        chk_flag("R6", 1'b0);
        p = (a + s) % 4;
        exp_hit = (a >= s);
        step(1'b1, a, a[0], p, 1'b0, 1'b0);
        chk_flag(exp_hit ? "R2" : "R3", exp_hit);
        if (exp_hit) begin
          chk_fields("R2", a, a % 2, p);
          step(1'b1, 15, ~a[0], p + 1, 1'b0, 1'b0);
          chk_flag("R5", 1'b1);
          chk_fields("R5", a, a % 2, p);
          // R6: writing 1 to the valid bit changes nothing
          step(1'b0, 0, 1'b0, 0, 1'b1, 1'b1);
          chk_flag("R6", 1'b1);
        end
      end
    end

    // R4: strobe low with out-of-range address
    region_size = 4'd3;
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    for (int a = 0; a < 16; a++) begin
      step(1'b0, a, 1'b1, 3, 1'b0, 1'b0);
      chk_flag("R4", 1'b0);
    end

    // R10: fields kept across clear
    step(1'b1, 9, 1'b1, 2, 1'b0, 1'b0);
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    chk_flag("R10", 1'b0);
    chk_fields("R10", 9, 1, 2);
    step(1'b1, 1, 1'b0, 1, 1'b0, 1'b0);
    chk_fields("R10", 9, 1, 2);

    // R9: violation with simultaneous clear is captured
    step(1'b1, 5, 1'b1, 3, 1'b0, 1'b0);
    chk_fields("R2", 5, 1, 3);
    step(1'b1, 12, 1'b0, 1, 1'b1, 1'b0);
    chk_flag("R9", 1'b1);
    chk_fields("R9", 12, 0, 1);

    // R3 boundary in range at size-1
    region_size = 4'd8;
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    step(1'b1, 7, 1'b1, 1, 1'b0, 1'b0);
    chk_flag("R3", 1'b0);
    chk_fields("R3", 12, 0, 1);
    step(1'b1, 8, 1'b1, 1, 1'b0, 1'b0);
    chk_flag("R3", 1'b1);
    chk_fields("R3", 8, 1, 1);

    // R1 again: asynchronous reset clears everything
    #1 rst_n = 1'b0;
    #1;
    chk_flag("R1", 1'b0);
    chk_fields("R1", 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule